// File: doc/BRIEF.md
# Write-Data Route Credit Tracker

This block sits next to a router that sends write addresses from one upstream source to one of several output ports. It decides which output port receives each write-data beat. It does not keep a queue of routing decisions. It keeps two things instead: the target port of the most recent committed address, and a count of write bursts whose address has been committed but whose last data beat has not yet been taken.

Because only one target is remembered, all open bursts must go to the same port. A new address aimed at a different port is held back until the count drains to zero. This keeps write data from interleaving between ports and rules out the deadlock that interleaving could cause. When no burst is open, data follows the live address target, so a beat can pass in the same cycle as its own address.

The address router uses `addr_allow` as a permission gate. It signals `addr_commit` when it forwards an address.

Top module: `wdata_route_tracker`

## Requirements
- R1: After reset the open count is zero and the stored target is port 0. With no address present, `addr_allow` is high for any target, no `port_wvalid` bit is set and `wd_ready` is low.
- R2: The open count rises by one in a cycle where `addr_valid`, `addr_allow` and `addr_commit` are all high. `addr_commit` has no effect while `addr_valid` is low.
- R3: The open count falls by one when a beat with `wd_last` high is handshaken (`wd_valid` and `wd_ready` both high). If a rise and a fall happen in the same cycle, the count is unchanged.
- R4: `addr_allow` is high only when the open count is zero or `addr_target` equals the stored target.
- R5: `addr_allow` is low while the open count holds its all-ones value. For the default parameters, that value is 7.
- R6: The stored target takes the value of `addr_target` on every rise of the count and holds otherwise.
- R7: The effective target is the stored target while the count is non-zero, and `addr_target` while the count is zero. A data beat can therefore pass in the same cycle that its address is committed.
- R8: Routing is active only in a cycle with a count rise or a non-zero count. While routing is active, only bit `port_wvalid[t]` of the effective target t mirrors `wd_valid`, and `wd_ready` equals `port_wready[t]`. While routing is inactive, every `port_wvalid` bit and `wd_ready` are low.
- R9: A fall of the count while it is zero is illegal. With the count at zero and no address, a last beat is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_valid | input | 1 | A write address is presented |
| addr_target | input | SEL_W | Output port selected by that address |
| addr_commit | input | 1 | Address is forwarded this cycle (accept strobe) |
| addr_allow | output | 1 | Permission for the address to go ahead |
| wd_valid | input | 1 | Upstream write-data beat valid |
| wd_last | input | 1 | Beat is the last of its burst |
| wd_ready | output | 1 | Upstream write-data ready |
| port_wready | input | NUM_PORTS | Per-port write-data ready |
| port_wvalid | output | NUM_PORTS | Per-port write-data valid |

## Verification
The assertions assume that `addr_target` is below NUM_PORTS whenever `addr_valid` is high. They also assume that a count fall only comes from a beat the block itself marked ready. Under those assumptions an underflow can only come from a broken route gate, and never from the stimulus. The bench draws targets only from the four existing ports. Its randomised phase mixes same-port and alternating-port addresses with random ready stalls. It predicts routing from a reference count and target held in the bench.

// File: rtl/wrt_pkg.sv
package wrt_pkg;

    // Width of an index or counter able to hold n-1, never below one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wrt_admit_gate.sv
module wrt_admit_gate #(
    parameter int unsigned CNT_W = 3,
    parameter int unsigned SEL_W = 2
) (
    input  logic [CNT_W-1:0] open_count,
    input  logic [SEL_W-1:0] held_target,
    input  logic [SEL_W-1:0] addr_target,
    output logic             addr_allow
);

    logic cnt_full;
    logic cnt_zero;
    logic same_port;

    always_comb begin
        cnt_full   = (open_count == {CNT_W{1'b1}});
        cnt_zero   = (open_count == '0);
        same_port  = (addr_target == held_target);
        addr_allow = !cnt_full && (cnt_zero || same_port);
    end

endmodule

// File: rtl/wrt_port_steer.sv
module wrt_port_steer #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned SEL_W     = 2
) (
    input  logic                 route_valid,
    input  logic [SEL_W-1:0]     eff_target,
    input  logic                 wd_valid,
    input  logic                 wd_last,
    input  logic [NUM_PORTS-1:0] port_wready,
    output logic [NUM_PORTS-1:0] port_wvalid,
    output logic                 wd_ready,
    output logic                 burst_done
);

    logic [NUM_PORTS-1:0] hit;
    logic [NUM_PORTS-1:0] rdy_sel;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign hit[p]         = route_valid && (eff_target == SEL_W'(p));
        assign port_wvalid[p] = hit[p] && wd_valid;
        assign rdy_sel[p]     = hit[p] && port_wready[p];
    end

    always_comb begin
        wd_ready   = |rdy_sel;
        burst_done = wd_valid && wd_ready && wd_last;
    end

endmodule

// File: rtl/wdata_route_tracker.sv
module wdata_route_tracker #(
    parameter int unsigned NUM_PORTS       = 4,
    parameter int unsigned MAX_OUTSTANDING = 8,
    localparam int unsigned SEL_W          = wrt_pkg::idx_bits(NUM_PORTS),
    localparam int unsigned CNT_W          = wrt_pkg::idx_bits(MAX_OUTSTANDING)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 addr_valid,
    input  logic [SEL_W-1:0]     addr_target,
    input  logic                 addr_commit,
    output logic                 addr_allow,
    input  logic                 wd_valid,
    input  logic                 wd_last,
    output logic                 wd_ready,
    input  logic [NUM_PORTS-1:0] port_wready,
    output logic [NUM_PORTS-1:0] port_wvalid
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [SEL_W-1:0] target;
    } track_t;

    track_t           st_d, st_q;
    logic             inc, dec;
    logic             route_valid;
    logic [SEL_W-1:0] eff_target;

    wrt_admit_gate #(
        .CNT_W (CNT_W),
        .SEL_W (SEL_W)
    ) u_gate (
        .open_count  (st_q.count),
        .held_target (st_q.target),
        .addr_target (addr_target),
        .addr_allow  (addr_allow)
    );

    always_comb begin
        inc         = addr_valid && addr_allow && addr_commit;
        eff_target  = (st_q.count != '0) ? st_q.target : addr_target;
        route_valid = inc || (st_q.count != '0);
    end

    wrt_port_steer #(
        .NUM_PORTS (NUM_PORTS),
        .SEL_W     (SEL_W)
    ) u_steer (
        .route_valid (route_valid),
        .eff_target  (eff_target),
        .wd_valid    (wd_valid),
        .wd_last     (wd_last),
        .port_wready (port_wready),
        .port_wvalid (port_wvalid),
        .wd_ready    (wd_ready),
        .burst_done  (dec)
    );

    always_comb begin
        st_d = st_q;
        if (inc ^ dec) begin
            st_d.count = inc ? (st_q.count + 1'b1) : (st_q.count - 1'b1);
        end
        if (inc) begin
            st_d.target = addr_target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wrt_checker.sv
module wrt_checker #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned CNT_W     = 3,
    parameter int unsigned SEL_W     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [SEL_W-1:0]     addr_target,
    input logic                 addr_allow,
    input logic                 wd_valid,
    input logic [NUM_PORTS-1:0] port_wvalid,
    input logic [CNT_W-1:0]     count,
    input logic [SEL_W-1:0]     target,
    input logic                 inc,
    input logic                 dec
);

    assert_gate_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0 && addr_target != target) |-> !addr_allow);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count == {CNT_W{1'b1}}) |-> !addr_allow);

    assert_count_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec) |=> (count == $past(count) + 1'b1));

    assert_count_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |=> (count == $past(count) - 1'b1));

    assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc == dec) |=> $stable(count));

    assert_target_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (target == $past(addr_target)));

    assert_target_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(target));

    assert_single_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_wvalid));

    assert_valid_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_wvalid) |-> wd_valid);

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !inc) |-> !dec);

endmodule

bind wdata_route_tracker wrt_checker #(
    .NUM_PORTS (NUM_PORTS),
    .CNT_W     (CNT_W),
    .SEL_W     (SEL_W)
) u_wrt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_target (addr_target),
    .addr_allow  (addr_allow),
    .wd_valid    (wd_valid),
    .port_wvalid (port_wvalid),
    .count       (st_q.count),
    .target      (st_q.target),
    .inc         (inc),
    .dec         (dec)
);

// File: tb/wdata_route_tracker_bench.sv
module wdata_route_tracker_bench;

    localparam int NP = 4;
    localparam int FULL = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_valid = 1'b0;
    logic [1:0] addr_target = '0;
    logic       addr_commit = 1'b0;
    logic       addr_allow;
    logic       wd_valid = 1'b0;
    logic       wd_last = 1'b0;
    logic       wd_ready;
    logic [3:0] port_wready = '0;
    logic [3:0] port_wvalid;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wdata_route_tracker #(
        .NUM_PORTS       (NP),
        .MAX_OUTSTANDING (8)
    ) u_wdata_route_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_valid  (addr_valid),
        .addr_target (addr_target),
        .addr_commit (addr_commit),
        .addr_allow  (addr_allow),
        .wd_valid    (wd_valid),
        .wd_last     (wd_last),
        .wd_ready    (wd_ready),
        .port_wready (port_wready),
        .port_wvalid (port_wvalid)
    );

    typedef struct packed {
        bit       av;
        bit [1:0] tgt;
        bit       cm;
        bit       wv;
        bit       wl;
        bit [3:0] rdy;
        bit       ex_allow;
        bit [3:0] ex_pv;
        bit       ex_wr;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 4'hF, 1'b1, 4'h0, 1'b0}, // R1 R8 idle, no route
        '{1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 4'hF, 1'b1, 4'h4, 1'b1}, // R2 R7 same-cycle data
        '{1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 4'hF, 1'b0, 4'h4, 1'b1}, // R4 port change held
        '{1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 4'h0, 1'b0, 4'h4, 1'b0}, // R8 stall on last
        '{1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 4'h4, 1'b0, 4'h4, 1'b1}, // R3 last beat drains
        '{1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 4'h2, 1'b1, 4'h2, 1'b1}, // R3 rise+fall same cycle
        '{1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 4'h0, 1'b1}, // R6 load target 3
        '{1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 4'h0, 1'b1}, // R4 same port back-to-back
        '{1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 4'h8, 1'b0, 4'h8, 1'b1}, // R7 stored target used
        '{1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 4'h1, 1'b0, 4'h8, 1'b0}, // R8 other port ready ignored
        '{1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 4'h8, 1'b0, 4'h8, 1'b1}, // R3 drain to zero
        '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 4'hF, 1'b1, 4'h0, 1'b0}, // R2 no commit, no route
        '{1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 4'hF, 1'b1, 4'h0, 1'b0}, // R2 R9 commit w/o valid
        '{1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 4'hF, 1'b1, 4'h2, 1'b1}, // R7 live target at zero
        '{1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 4'hF, 1'b1, 4'h2, 1'b1}  // R3 final drain
    };

    task automatic check(input string tag, input bit ex_allow, input bit [3:0] ex_pv,
                         input bit ex_wr);
        compared++;
        if (addr_allow !== ex_allow || port_wvalid !== ex_pv || wd_ready !== ex_wr) begin
            mismatched++;
            $display("FAIL %s: allow/pv/ready actual %b/%h/%b expected %b/%h/%b",
                     tag, addr_allow, port_wvalid, wd_ready, ex_allow, ex_pv, ex_wr);
        end
    endtask

    task automatic drive(input bit av, input bit [1:0] tgt, input bit cm, input bit wv,
                         input bit wl, input bit [3:0] rdy);
        @(negedge clk);
        addr_valid  = av;
        addr_target = tgt;
        addr_commit = cm;
        wd_valid    = wv;
        wd_last     = wl;
        port_wready = rdy;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        addr_valid = 1'b0; addr_commit = 1'b0; wd_valid = 1'b0; wd_last = 1'b0;
        port_wready = '0; addr_target = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int cycles = 0;
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                mismatched++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    initial begin
        int m_cnt;
        int m_tgt;
        do_reset();

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].av, VECS[i].tgt, VECS[i].cm, VECS[i].wv, VECS[i].wl, VECS[i].rdy);
            check($sformatf("table step %0d", i), VECS[i].ex_allow, VECS[i].ex_pv,
                  VECS[i].ex_wr);
        end

        // R1: reset state, with a last beat offered and no address (R9: not accepted)
        drive(1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 4'hF);
        do_reset();
        drive(1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 4'hF);
        check("R1 R9 reset: no route, last beat refused", 1'b1, 4'h0, 1'b0);
        drive(1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 4'hF);
        check("R1 allow any target after reset", 1'b1, 4'h0, 1'b0);

        // R5: fill to all ones on port 2, then full blocks even a matching target
        for (int k = 0; k < FULL; k++) begin
            drive(1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 4'h0);
            check($sformatf("R5 fill step %0d", k), 1'b1, 4'h0, 1'b0);
        end
        drive(1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 4'h0);
        check("R5 full blocks matching address", 1'b0, 4'h0, 1'b0);
        drive(1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 4'h4);
        check("R5 drain one while full", 1'b0, 4'h4, 1'b1);
        drive(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 4'h4);
        check("R5 space after one drain", 1'b1, 4'h0, 1'b1);
        for (int k = 0; k < FULL - 1; k++) begin
            drive(1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 4'h4);
            check($sformatf("R3 drain step %0d", k), 1'b0, 4'h4, 1'b1);
        end
        drive(1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 4'hF);
        check("R3 R8 count back at zero", 1'b1, 4'h0, 1'b0);

        // Randomised: same and alternating targets with data stalls (R4 R7 R8)
        m_cnt = 0;
        m_tgt = 0;
        for (int c = 0; c < 600; c++) begin
            bit av, cm, wv, wl, ex_allow, inc, rv, ex_wr, dec;
            bit [1:0] tgt;
            bit [3:0] rdy, ex_pv;
            int eff;
            av  = ($urandom % 4) != 0;
            tgt = (($urandom % 2) == 0) ? 2'(m_tgt) : 2'($urandom % NP);
            cm  = ($urandom % 3) != 0;
            wv  = ($urandom % 3) != 0;
            wl  = ($urandom % 3) == 0;
            rdy = 4'($urandom);
            ex_allow = (m_cnt < FULL) && (m_cnt == 0 || int'(tgt) == m_tgt);
            inc = av && ex_allow && cm;
            eff = (m_cnt != 0) ? m_tgt : int'(tgt);
            rv  = inc || (m_cnt != 0);
            ex_pv = (rv && wv) ? 4'(1 << eff) : 4'h0;
            ex_wr = rv && rdy[eff];
            dec = wv && ex_wr && wl;
            drive(av, tgt, cm, wv, wl, rdy);
            check($sformatf("R4 R7 R8 random cycle %0d", c), ex_allow, ex_pv, ex_wr);
            if (inc) m_tgt = int'(tgt);
            if (inc && !dec) m_cnt++;
            if (dec && !inc) m_cnt--;
        end

        @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule